// File: doc/BRIEF.md
# Timer Compare Unit with Period Trigger

This block holds a 16-bit up-counting timer and a 16-bit compare value and checks them for equality on every clock. When the two become equal, a 4-bit mode value picks the reaction: drive a compare output latch high, drive it low, only raise an interrupt flag, or issue a trigger event. A trigger event resets the timer to zero and sends a one-cycle conversion-start pulse. In trigger mode the compare value therefore acts as a period register, and the timer repeats every compare+1 counts without raising its overflow flag.

Software programs the unit through a byte-wide write port with four addresses. These hold the low and high compare bytes, the mode, and a flag-clear strobe. A run input advances the timer. A tristate bit decides whether the latch reaches the pin driver.

Match detection uses a two-state machine. In state MT_WAIT the timer differs from the compare value. In state MT_HELD it equals it. The move MT_WAIT→MT_HELD is the match event, and MT_HELD→MT_WAIT is re-arming. The output latch is a second two-state machine. Its states are PIN_LO and PIN_HI. A set-mode match moves it PIN_LO→PIN_HI. A clear-mode match or a zero mode write moves it PIN_HI→PIN_LO.

Top module: `cmp_trig_unit`

## Requirements
- R1: While `tmr_run` is 1 the timer adds one per clock, and it holds its value while `tmr_run` is 0. When it steps from 16'hFFFF to 0 it sets `ovf_flag`, which stays at 1 until it is cleared.
- R2: A write with `wr_en`=1 stores `wr_data` by address. Address 0 loads compare bits 7:0 and address 1 loads compare bits 15:8. Address 2 loads the mode from `wr_data[3:0]`. Address 3 is a clear strobe: bit 0 clears `irq_flag` and bit 1 clears `ovf_flag`.
- R3: A match event happens only in a cycle where the timer equals the compare value and did not equal it in the previous cycle. Coming out of reset counts as already equal. A timer that is held at the compare value produces no further events.
- R4: On a match event, mode 4'b1000 sets the output latch to 1 and mode 4'b1001 clears it to 0. The result is seen at the clock edge that ends the match cycle.
- R5: A match event in any mode 4'b10xx sets `irq_flag` at the edge that ends that cycle. The flag stays at 1 until a clear write. A clear write in the same cycle as a match event loses, and the flag ends at 1.
- R6: In mode 4'b1010 a match event sets `irq_flag` only, and the output latch keeps its value.
- R7: In mode 4'b1011 a match event resets the timer to 0 at the same edge and raises `go_pulse` for exactly one cycle. With a running timer started from 0, events occur every compare+1 cycles.
- R8: A timer reset caused by a trigger event never sets `ovf_flag`, even when the compare value is 16'hFFFF.
- R9: A write of 0 to the mode address forces the output latch to 0. This takes priority over a set-mode match in the same cycle.
- R10: `cmp_pin_oe` is the inverse of `pin_tris`. `cmp_pin_o` shows the latch while the pin is enabled and is 0 while it is disabled. The latch value is kept across a disabled period.
- R11: After reset, the mode, compare value, timer, latch and both flags are 0, and `go_pulse` is 0.
- R12: In a mode outside 4'b10xx a match sets no flag, leaves the latch unchanged and issues no trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the timer counts on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the register port |
| wr_addr | input | 2 | Register address (0 compare low, 1 compare high, 2 mode, 3 clear) |
| wr_data | input | 8 | Write data |
| tmr_run | input | 1 | Timer advance enable |
| pin_tris | input | 1 | 1 puts the compare pin into high-impedance (driver disabled) |
| cmp_pin_o | output | 1 | Compare pin data, 0 when the pin is disabled |
| cmp_pin_oe | output | 1 | Compare pin driver enable |
| irq_flag | output | 1 | Sticky compare interrupt flag |
| ovf_flag | output | 1 | Sticky timer wrap flag |
| go_pulse | output | 1 | One-cycle conversion-start request |

## Verification
Two things can land on the same clock edge. One is a match event that sets the interrupt flag. The other is a software clear write to address 3. The bench stops the timer two counts below a new compare value, runs it forward, and issues the clear write exactly in the cycle the timer reaches equality. After that edge the flag must read 1, and a second clear in the next cycle must bring it to 0. A constrained-random phase also produces such collisions by chance, and a bench-side cycle model judges every cycle. The same pattern is used for a zero mode write that lands on a set-mode match, where the latch must end at 0.

// File: rtl/cmp_trig_pkg.sv
package cmp_trig_pkg;

    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CMP_LO = 2'd0;
    localparam logic [ADDR_W-1:0] A_CMP_HI = 2'd1;
    localparam logic [ADDR_W-1:0] A_MODE   = 2'd2;
    localparam logic [ADDR_W-1:0] A_CLEAR  = 2'd3;

    typedef enum logic [3:0] {
        MD_OFF  = 4'b0000,
        MD_SET  = 4'b1000,
        MD_CLR  = 4'b1001,
        MD_SWI  = 4'b1010,
        MD_TRIG = 4'b1011
    } cmp_mode_e;

    typedef enum logic {MT_WAIT, MT_HELD} match_st_e;
    typedef enum logic {PIN_LO, PIN_HI} pin_st_e;

    function automatic logic mode_active(input logic [3:0] m);
        return m[3:2] == 2'b10;
    endfunction

endpackage

// File: rtl/cmp_regs.sv
module cmp_regs
    import cmp_trig_pkg::*;
#(
    parameter int TMR_W  = 16,
    parameter int BYTE_W = 8,
    parameter int MODE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [BYTE_W-1:0]  wr_data,
    output logic [TMR_W-1:0]   cmp_val,
    output logic [MODE_W-1:0]  mode,
    output logic               mode_zero_wr,
    output logic               flag_clr,
    output logic               ovf_clr
);

    localparam int LANES = TMR_W / BYTE_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cmp_val[g*BYTE_W +: BYTE_W] <= '0;
            end else if (wr_en && wr_addr == ADDR_W'(g)) begin
                cmp_val[g*BYTE_W +: BYTE_W] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode <= '0;
        end else if (wr_en && wr_addr == A_MODE) begin
            mode <= wr_data[MODE_W-1:0];
        end
    end

    always_comb begin
        mode_zero_wr = wr_en && (wr_addr == A_MODE) && (wr_data[MODE_W-1:0] == '0);
        flag_clr     = wr_en && (wr_addr == A_CLEAR) && wr_data[0];
        ovf_clr      = wr_en && (wr_addr == A_CLEAR) && wr_data[1];
    end

endmodule

// File: rtl/cmp_timer.sv
module cmp_timer #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tmr_clr,
    input  logic             ovf_clr,
    output logic [TMR_W-1:0] count,
    output logic             ovf_flag
);

    logic wrap;

    always_comb begin
        wrap = run && !tmr_clr && (count == '1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (tmr_clr) begin
            count <= '0;
        end else if (run) begin
            count <= count + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
        end else if (wrap) begin
            ovf_flag <= 1'b1;
        end else if (ovf_clr) begin
            ovf_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/cmp_match_fsm.sv
module cmp_match_fsm
    import cmp_trig_pkg::*;
#(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TMR_W-1:0] count,
    input  logic [TMR_W-1:0] cmp_val,
    output logic             hit
);

    match_st_e state_q, state_d;
    logic      equal;

    always_comb begin
        equal = (count == cmp_val);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MT_HELD;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        hit     = 1'b0;
        unique case (state_q)
            MT_WAIT: begin
                hit = equal;
                if (equal) state_d = MT_HELD;
            end
            MT_HELD: begin
                if (!equal) state_d = MT_WAIT;
            end
            default: state_d = MT_HELD;
        endcase
    end

endmodule

// File: rtl/cmp_action.sv
module cmp_action
    import cmp_trig_pkg::*;
#(
    parameter int MODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic [MODE_W-1:0] mode,
    input  logic              mode_zero_wr,
    input  logic              flag_clr,
    output logic              fire,
    output logic              tmr_clr,
    output logic              pin_lat,
    output logic              irq_flag,
    output logic              go_pulse
);

    pin_st_e pin_q, pin_d;

    always_comb begin
        fire    = hit && mode_active(mode);
        tmr_clr = fire && (mode == MD_TRIG);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= PIN_LO;
        end else begin
            pin_q <= pin_d;
        end
    end

    always_comb begin
        pin_d = pin_q;
        if (mode_zero_wr) begin
            pin_d = PIN_LO;
        end else if (fire) begin
            unique case (pin_q)
                PIN_LO:  if (mode == MD_SET) pin_d = PIN_HI;
                PIN_HI:  if (mode == MD_CLR) pin_d = PIN_LO;
                default: pin_d = PIN_LO;
            endcase
        end
    end

    always_comb begin
        pin_lat = (pin_q == PIN_HI);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_flag <= 1'b0;
            go_pulse <= 1'b0;
        end else begin
            go_pulse <= tmr_clr;
            if (fire) begin
                irq_flag <= 1'b1;
            end else if (flag_clr) begin
                irq_flag <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/cmp_trig_unit.sv
module cmp_trig_unit
    import cmp_trig_pkg::*;
#(
    parameter int TMR_W  = 16,
    parameter int BYTE_W = 8,
    parameter int MODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              tmr_run,
    input  logic              pin_tris,
    output logic              cmp_pin_o,
    output logic              cmp_pin_oe,
    output logic              irq_flag,
    output logic              ovf_flag,
    output logic              go_pulse
);

    logic [TMR_W-1:0]  count;
    logic [TMR_W-1:0]  cmp_val;
    logic [MODE_W-1:0] mode;
    logic              mode_zero_wr;
    logic              flag_clr;
    logic              ovf_clr;
    logic              hit;
    logic              fire;
    logic              tmr_clr;
    logic              pin_lat;

    cmp_regs #(.TMR_W(TMR_W), .BYTE_W(BYTE_W), .MODE_W(MODE_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .cmp_val      (cmp_val),
        .mode         (mode),
        .mode_zero_wr (mode_zero_wr),
        .flag_clr     (flag_clr),
        .ovf_clr      (ovf_clr)
    );

    cmp_timer #(.TMR_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (tmr_run),
        .tmr_clr  (tmr_clr),
        .ovf_clr  (ovf_clr),
        .count    (count),
        .ovf_flag (ovf_flag)
    );

    cmp_match_fsm #(.TMR_W(TMR_W)) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .count   (count),
        .cmp_val (cmp_val),
        .hit     (hit)
    );

    cmp_action #(.MODE_W(MODE_W)) u_action (
        .clk          (clk),
        .rst_n        (rst_n),
        .hit          (hit),
        .mode         (mode),
        .mode_zero_wr (mode_zero_wr),
        .flag_clr     (flag_clr),
        .fire         (fire),
        .tmr_clr      (tmr_clr),
        .pin_lat      (pin_lat),
        .irq_flag     (irq_flag),
        .go_pulse     (go_pulse)
    );

    always_comb begin
        cmp_pin_oe = !pin_tris;
        cmp_pin_o  = pin_lat && !pin_tris;
    end

endmodule

// File: rtl/cmp_trig_chk.sv
module cmp_trig_chk
    import cmp_trig_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int MODE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [BYTE_W-1:0] wr_data,
    input logic              pin_tris,
    input logic              cmp_pin_o,
    input logic              cmp_pin_oe,
    input logic              irq_flag,
    input logic              ovf_flag,
    input logic              go_pulse,
    input logic              hit,
    input logic              fire,
    input logic              flag_clr,
    input logic [MODE_W-1:0] mode,
    input logic              pin_lat
);

    // R3
    hit_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit);

    // R5
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> irq_flag);

    // R5
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !flag_clr) |=> irq_flag);

    // R6
    swi_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && mode == MD_SWI && !(wr_en && wr_addr == A_MODE)) |=> $stable(pin_lat));

    // R7
    go_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_pulse |=> !go_pulse);

    // R8
    trig_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> !go_pulse);

    // R9
    mode_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_MODE && wr_data[MODE_W-1:0] == '0) |=> !pin_lat);

    // R10
    pin_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_tris |-> (!cmp_pin_oe && !cmp_pin_o));

    // R12
    idle_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !mode_active(mode) && !irq_flag && !flag_clr) |=> (!irq_flag && !go_pulse));

endmodule

bind cmp_trig_unit cmp_trig_chk #(.BYTE_W(BYTE_W), .MODE_W(MODE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .pin_tris   (pin_tris),
    .cmp_pin_o  (cmp_pin_o),
    .cmp_pin_oe (cmp_pin_oe),
    .irq_flag   (irq_flag),
    .ovf_flag   (ovf_flag),
    .go_pulse   (go_pulse),
    .hit        (hit),
    .fire       (fire),
    .flag_clr   (flag_clr),
    .mode       (mode),
    .pin_lat    (pin_lat)
);

// File: tb/cmp_trig_unit_test.sv
`timescale 1ns/1ps
module cmp_trig_unit_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       tmr_run = 1'b0;
    logic       pin_tris = 1'b0;
    logic       cmp_pin_o, cmp_pin_oe, irq_flag, ovf_flag, go_pulse;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    logic [15:0] m_tmr, m_cmp;
    logic [3:0]  m_mode;
    bit          m_lat, m_irq, m_ovf, m_go, m_held;

    always #2 clk = ~clk;

    cmp_trig_unit uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .tmr_run    (tmr_run),
        .pin_tris   (pin_tris),
        .cmp_pin_o  (cmp_pin_o),
        .cmp_pin_oe (cmp_pin_oe),
        .irq_flag   (irq_flag),
        .ovf_flag   (ovf_flag),
        .go_pulse   (go_pulse)
    );

    function automatic bit exp_pin(input bit lat, input bit tris);
        return lat && !tris;
    endfunction

    function automatic bit exp_active(input logic [3:0] m);
        return m[3:2] == 2'b10;
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_tmr = 16'd0; m_cmp = 16'd0; m_mode = 4'd0;
        m_lat = 0; m_irq = 0; m_ovf = 0; m_go = 0; m_held = 1;
    endtask

    task automatic model_step(input bit we, input logic [1:0] a, input logic [7:0] d, input bit run);
        bit eq, hit, fire, trig, mz, clr_i, clr_o;
        eq    = (m_tmr == m_cmp);
        hit   = eq && !m_held;
        fire  = hit && exp_active(m_mode);
        trig  = fire && (m_mode == 4'b1011);
        mz    = we && a == 2'd2 && d[3:0] == 4'd0;
        clr_i = we && a == 2'd3 && d[0];
        clr_o = we && a == 2'd3 && d[1];
        if (run && m_tmr == 16'hFFFF && !trig) m_ovf = 1;
        else if (clr_o) m_ovf = 0;
        if (fire) m_irq = 1;
        else if (clr_i) m_irq = 0;
        if (mz) m_lat = 0;
        else if (fire && m_mode == 4'b1000) m_lat = 1;
        else if (fire && m_mode == 4'b1001) m_lat = 0;
        m_go   = trig;
        m_held = eq;
        if (trig) m_tmr = 16'd0;
        else if (run) m_tmr = m_tmr + 16'd1;
        if (we && a == 2'd0) m_cmp[7:0] = d;
        if (we && a == 2'd1) m_cmp[15:8] = d;
        if (we && a == 2'd2) m_mode = d[3:0];
    endtask

    task automatic compare_all(input string tag);
        check(tag, "pin_oe", cmp_pin_oe, !pin_tris);
        check(tag, "pin_o", cmp_pin_o, exp_pin(m_lat, pin_tris));
        check(tag, "irq", irq_flag, m_irq);
        check(tag, "ovf", ovf_flag, m_ovf);
        check(tag, "go", go_pulse, m_go);
    endtask

    task automatic cyc(input bit we, input logic [1:0] a, input logic [7:0] d, input bit run, input string tag);
        wr_en = we; wr_addr = a; wr_data = d; tmr_run = run;
        model_step(we, a, d, run);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        compare_all(tag);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d, input string tag);
        cyc(1'b1, a, d, 1'b0, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; tmr_run = 1'b0; pin_tris = 1'b0;
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        compare_all("R11");
    endtask

    task automatic idle(input int n, input bit run, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, 2'd0, 8'd0, run, tag);
    endtask

    initial begin
        logic [7:0] modes [8];
        int r;
        modes = '{8'h00, 8'h08, 8'h09, 8'h0A, 8'h0B, 8'h05, 8'h0C, 8'h0F};
        r = $urandom(32'h5EED);

        do_reset();

        // R4 set then clear on match
        wr(2'd0, 8'd5, "R2");
        wr(2'd2, 8'h08, "R4");
        idle(5, 1, "R1");
        check("R4", "pin before match", cmp_pin_o, 1'b0);
        idle(1, 1, "R4");
        check("R4", "pin set", cmp_pin_o, 1'b1);
        check("R5", "irq set", irq_flag, 1'b1);
        wr(2'd2, 8'h09, "R4");
        wr(2'd3, 8'h01, "R5");
        check("R5", "irq cleared", irq_flag, 1'b0);
        wr(2'd0, 8'd9, "R4");
        idle(3, 1, "R1");
        check("R4", "pin still high", cmp_pin_o, 1'b1);
        idle(1, 1, "R4");
        check("R4", "pin cleared", cmp_pin_o, 1'b0);

        // R6 and R3: software-only mode, held timer
        do_reset();
        wr(2'd0, 8'd2, "R2");
        wr(2'd2, 8'h08, "R4");
        idle(3, 1, "R4");
        check("R4", "pin set", cmp_pin_o, 1'b1);
        wr(2'd2, 8'h0A, "R6");
        wr(2'd3, 8'h01, "R5");
        wr(2'd0, 8'd5, "R6");
        idle(2, 1, "R6");
        idle(1, 0, "R6");
        check("R6", "irq on swi match", irq_flag, 1'b1);
        check("R6", "pin unchanged", cmp_pin_o, 1'b1);
        wr(2'd3, 8'h01, "R3");
        idle(5, 0, "R3");
        check("R3", "no repeat while held", irq_flag, 1'b0);

        // R10 tristate keeps latch
        pin_tris = 1'b1;
        idle(1, 0, "R10");
        check("R10", "oe off", cmp_pin_oe, 1'b0);
        check("R10", "pin off", cmp_pin_o, 1'b0);
        pin_tris = 1'b0;
        idle(1, 0, "R10");
        check("R10", "latch kept", cmp_pin_o, 1'b1);

        // R5 set beats clear in the same cycle
        wr(2'd0, 8'd7, "R5");
        idle(2, 1, "R5");
        cyc(1'b1, 2'd3, 8'h01, 1'b1, "R5");
        check("R5", "set wins over clear", irq_flag, 1'b1);
        cyc(1'b1, 2'd3, 8'h01, 1'b0, "R5");
        check("R5", "later clear", irq_flag, 1'b0);

        // R9 zero mode write on a set match, then plain
        do_reset();
        wr(2'd0, 8'd2, "R9");
        wr(2'd2, 8'h08, "R9");
        idle(2, 1, "R9");
        cyc(1'b1, 2'd2, 8'h00, 1'b1, "R9");
        check("R9", "zero write wins", cmp_pin_o, 1'b0);
        check("R9", "flag from set match", irq_flag, 1'b1);
        wr(2'd2, 8'h08, "R9");
        wr(2'd0, 8'd5, "R9");
        idle(3, 1, "R9");
        check("R9", "pin set", cmp_pin_o, 1'b1);
        wr(2'd2, 8'h00, "R9");
        check("R9", "zero write clears", cmp_pin_o, 1'b0);

        // R12 inactive mode
        do_reset();
        wr(2'd0, 8'd2, "R12");
        wr(2'd2, 8'h05, "R12");
        idle(6, 1, "R12");
        check("R12", "no irq", irq_flag, 1'b0);
        check("R12", "no go", go_pulse, 1'b0);
        check("R12", "no pin", cmp_pin_o, 1'b0);

        // R7 trigger period
        do_reset();
        wr(2'd0, 8'd7, "R7");
        wr(2'd2, 8'h0B, "R7");
        idle(7, 1, "R7");
        check("R7", "no go early", go_pulse, 1'b0);
        idle(1, 1, "R7");
        check("R7", "first go", go_pulse, 1'b1);
        idle(1, 1, "R7");
        check("R7", "go one cycle", go_pulse, 1'b0);
        idle(6, 1, "R7");
        check("R7", "no go mid period", go_pulse, 1'b0);
        idle(1, 1, "R7");
        check("R7", "second go after cmp+1", go_pulse, 1'b1);

        // constrained random
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            int sel;
            bit run;
            sel = $urandom % 100;
            run = ($urandom % 10) != 0;
            if ($urandom % 20 == 0) pin_tris = ~pin_tris;
            if (sel < 10)      cyc(1'b1, 2'd0, 8'($urandom % 40), run, "R2 random");
            else if (sel < 13) cyc(1'b1, 2'd1, 8'($urandom % 2) == 0 ? 8'd0 : 8'd0, run, "R2 random");
            else if (sel < 20) cyc(1'b1, 2'd2, modes[$urandom % 8], run, "R12 random");
            else if (sel < 26) cyc(1'b1, 2'd3, 8'($urandom % 4), run, "R5 random");
            else               cyc(1'b0, 2'd0, 8'd0, run, "R3 random");
        end
        pin_tris = 1'b0;

        // R8 trigger at all-ones, then R1 wrap
        do_reset();
        wr(2'd0, 8'hFF, "R2");
        wr(2'd1, 8'hFF, "R2");
        wr(2'd2, 8'h0B, "R8");
        idle(65535, 1, "R8");
        check("R8", "no go yet", go_pulse, 1'b0);
        idle(1, 1, "R8");
        check("R8", "go at all-ones", go_pulse, 1'b1);
        check("R8", "no overflow on trigger", ovf_flag, 1'b0);
        wr(2'd2, 8'h00, "R1");
        wr(2'd3, 8'h01, "R1");
        idle(65535, 1, "R1");
        check("R1", "no wrap yet", ovf_flag, 1'b0);
        idle(1, 1, "R1");
        check("R1", "wrap sets ovf", ovf_flag, 1'b1);
        check("R12", "mode off no irq", irq_flag, 1'b0);
        wr(2'd3, 8'h02, "R2");
        check("R2", "ovf cleared", ovf_flag, 1'b0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog run did not finish actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule